// File: doc/BRIEF.md
# Tape File Skip Sequencer

This block carries out the skip-by-files positioning commands of a tape controller, in both directions. On a start pulse it takes a 16-bit file count, a direction mode and two option bits. It then moves the tape one object at a time. For each object it raises a single-cycle step request and waits for the tape side to say what it passed over: a data record, a tape mark, the beginning of tape (reverse only), the end of the medium, or an unreadable record.

Only tape marks consume the file count. The block exports the remaining count continuously so that a message packet can carry it. When the count reaches zero, or an ending condition occurs, the block pulses `done`. Alongside it, the block presents a packed result made of an eight-bit status flag field and a three-bit termination class. With the stop-on-double-mark option, two marks with no data record between them end the skip early. With the leading-mark option, a forward skip that starts at the beginning of tape treats that position as if a mark had just been passed.

Top module: `tape_file_skipper`

## Requirements
- R1: After reset `done`, `step_req` and `busy` are 0 and `residual` is 0.
- R2: A start loads `residual` with `file_count`. Each tape mark decrements it modulo 2^16, and data records leave it unchanged. A count of 0 therefore wraps to 0xFFFF on the first mark.
- R3: The block issues exactly one single-cycle `step_req` per object. It issues the next one only after the response to the previous one. `step_dir` is 1 for mode 3 (reverse) and 0 for mode 2 (forward).
- R4: Flag bit 3 (moved) is set in the result if any data record, tape mark or unreadable record was passed during the skip. It stays clear otherwise.
- R5: With the stop option set, a mark that directly follows a mark ends the skip with class 2. The flags are bit 0 (mark) and bit 2 (logical end), plus bit 1 (short) if the residual after that mark is nonzero.
- R6: With the stop option clear, consecutive marks do not end the skip, and a data record between two marks cancels the pairing.
- R7: A forward skip starting at beginning of tape with the leading-mark option set treats the first mark as the second of a pair.
- R8: Reaching beginning of tape in reverse ends with class 2 and flags bit 4 (at BOT), bit 1 (short) and bit 7 (reversed into BOT).
- R9: End of medium ends with class 6 and flags bit 1 (short) and bit 6 (incomplete).
- R10: An unreadable record ends with class 6 and flags bit 3 (moved), bit 5 (uncorrectable) and bit 1 (short).
- R11: When a mark brings the residual to zero (and no double-mark stop applies), the skip ends with class 0 and no flag other than moved.
- R12: `done` is a one-cycle pulse, high the cycle after the response that ends the skip, and the result is valid with it.

Response codes on `rsp_kind`: 0 data record, 1 tape mark, 2 beginning of tape, 3 end of medium, 4 to 7 unreadable record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a skip (accepted when idle) |
| mode | input | 2 | 2 = forward, 3 = reverse |
| file_count | input | 16 | Number of tape marks to pass |
| opt_stop_double | input | 1 | Stop on two consecutive marks |
| opt_bot_mark | input | 1 | Beginning of tape counts as a mark on forward skips |
| at_bot | input | 1 | Tape sits at beginning of tape when start is given |
| step_req | output | 1 | Request one object to be passed |
| step_dir | output | 1 | Direction of the requested step, 1 = reverse |
| rsp_valid | input | 1 | Response to the outstanding step is present |
| rsp_kind | input | 3 | What the step passed (codes above) |
| busy | output | 1 | A skip is in progress |
| residual | output | 16 | Remaining file count |
| done | output | 1 | One-cycle end-of-skip pulse |
| res_flags | output | 8 | Status flags, bit positions as in the requirements |
| res_class | output | 3 | Termination class |

## Verification
The first `step_req` rises one cycle after `start` is sampled. Each later one rises one cycle after the previous response is taken. The response is taken on the edge where `rsp_valid` is high and the block waits. `residual` changes on that same edge, and `done` together with the result appears on the following cycle. The bench drives on falling edges and samples on falling edges. It answers each request on the falling edge after it sees it, and it compares the result, class and residual on the falling edge where `done` is high. The next falling edge confirms that `done` has dropped.

// File: rtl/tape_skip_pkg.sv
package tape_skip_pkg;

    localparam int CNT_W   = 16;
    localparam int KIND_W  = 3;
    localparam int CLASS_W = 3;

    typedef enum logic [KIND_W-1:0] {
        RSP_DATA = 3'd0,
        RSP_MARK = 3'd1,
        RSP_BOT  = 3'd2,
        RSP_EOM  = 3'd3,
        RSP_ERR  = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } state_e;

    // bit 0 is mark_seen, bit 7 is rev_bot
    typedef struct packed {
        logic rev_bot;
        logic incomplete;
        logic uncorr;
        logic at_bot;
        logic moved;
        logic log_end;
        logic short_rec;
        logic mark_seen;
    } flags_t;

    typedef struct packed {
        flags_t               flags;
        logic [CLASS_W-1:0]   cls;
    } result_t;

    localparam logic [CLASS_W-1:0] CLS_OK    = 3'd0;
    localparam logic [CLASS_W-1:0] CLS_ALERT = 3'd2;
    localparam logic [CLASS_W-1:0] CLS_LOST  = 3'd6;

    localparam logic [1:0] MODE_FWD = 2'd2;
    localparam logic [1:0] MODE_REV = 2'd3;

endpackage

// File: rtl/tsk_residual.sv
module tsk_residual #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - ONE;
    end

    AST_RES_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && cnt != $past(cnt)) |-> cnt == $past(cnt) - ONE); // R2

endmodule

// File: rtl/tsk_step_fsm.sv
module tsk_step_fsm
    import tape_skip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rsp_valid,
    input  logic stop,
    output logic step_req,
    output logic busy,
    output logic load,
    output logic accept,
    output logic finish
);
    state_e state, nxt;

    always_comb begin
        nxt    = state;
        load   = 1'b0;
        accept = 1'b0;
        finish = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                load = 1'b1;
                nxt  = ST_REQ;
            end
            ST_REQ:  nxt = ST_WAIT;
            ST_WAIT: if (rsp_valid) begin
                accept = 1'b1;
                finish = stop;
                nxt    = stop ? ST_IDLE : ST_REQ;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign step_req = (state == ST_REQ);
    assign busy     = (state != ST_IDLE);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_req |=> !step_req); // R3

    AST_NO_REQ_WAITING: assert property (@(posedge clk) disable iff (rst)
        (accept && !finish) |=> step_req); // R3

endmodule

// File: rtl/tsk_judge.sv
module tsk_judge
    import tape_skip_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [KIND_W-1:0] kind,
    input  logic              prev_mark,
    input  logic              stop_dbl,
    input  logic [W-1:0]      cnt,
    output logic              stop,
    output logic              dec,
    output logic              nxt_prev,
    output result_t           res
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] rem;

    assign rem = cnt - ONE;

    always_comb begin
        res      = '0;
        stop     = 1'b0;
        dec      = 1'b0;
        nxt_prev = prev_mark;
        unique case (rsp_e'(kind))
            RSP_DATA: begin
                res.flags.moved = 1'b1;
                nxt_prev        = 1'b0;
            end
            RSP_MARK: begin
                res.flags.moved = 1'b1;
                dec             = 1'b1;
                if (prev_mark && stop_dbl) begin
                    stop                = 1'b1;
                    res.flags.mark_seen = 1'b1;
                    res.flags.log_end   = 1'b1;
                    res.flags.short_rec = (rem != '0);
                    res.cls             = CLS_ALERT;
                end else begin
                    nxt_prev = 1'b1;
                    stop     = (rem == '0);
                    res.cls  = CLS_OK;
                end
            end
            RSP_BOT: begin
                stop                = 1'b1;
                res.flags.at_bot    = 1'b1;
                res.flags.short_rec = 1'b1;
                res.flags.rev_bot   = 1'b1;
                res.cls             = CLS_ALERT;
            end
            RSP_EOM: begin
                stop                 = 1'b1;
                res.flags.short_rec  = 1'b1;
                res.flags.incomplete = 1'b1;
                res.cls              = CLS_LOST;
            end
            default: begin
                stop                = 1'b1;
                res.flags.moved     = 1'b1;
                res.flags.uncorr    = 1'b1;
                res.flags.short_rec = 1'b1;
                res.cls             = CLS_LOST;
            end
        endcase
    end

endmodule

// File: rtl/tape_file_skipper.sv
module tape_file_skipper
    import tape_skip_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [CW-1:0]      file_count,
    input  logic               opt_stop_double,
    input  logic               opt_bot_mark,
    input  logic               at_bot,
    output logic               step_req,
    output logic               step_dir,
    input  logic               rsp_valid,
    input  logic [KIND_W-1:0]  rsp_kind,
    output logic               busy,
    output logic [CW-1:0]      residual,
    output logic               done,
    output logic [7:0]         res_flags,
    output logic [CLASS_W-1:0] res_class
);
    logic    load, accept, finish;
    logic    j_stop, j_dec, j_prev;
    result_t j_res, fin_res, res_q;
    logic    rev_q, stop_q, prev_q, moved_q, done_q;

    tsk_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rsp_valid (rsp_valid),
        .stop      (j_stop),
        .step_req  (step_req),
        .busy      (busy),
        .load      (load),
        .accept    (accept),
        .finish    (finish)
    );

    tsk_judge #(.W(CW)) u_judge (
        .kind      (rsp_kind),
        .prev_mark (prev_q),
        .stop_dbl  (stop_q),
        .cnt       (residual),
        .stop      (j_stop),
        .dec       (j_dec),
        .nxt_prev  (j_prev),
        .res       (j_res)
    );

    tsk_residual #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (file_count),
        .dec      (accept && j_dec),
        .cnt      (residual)
    );

    always_comb begin
        fin_res             = j_res;
        fin_res.flags.moved = j_res.flags.moved | moved_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rev_q   <= 1'b0;
            stop_q  <= 1'b0;
            prev_q  <= 1'b0;
            moved_q <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= finish;
            if (load) begin
                rev_q   <= (mode == MODE_REV);
                stop_q  <= opt_stop_double;
                prev_q  <= (mode == MODE_FWD) && at_bot && opt_bot_mark;
                moved_q <= 1'b0;
            end else if (accept) begin
                prev_q  <= j_prev;
                moved_q <= moved_q | j_res.flags.moved;
            end
            if (finish) res_q <= fin_res;
        end
    end

    assign step_dir  = rev_q;
    assign done      = done_q;
    assign res_flags = res_q.flags;
    assign res_class = res_q.cls;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_CLS0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && res_class == CLS_OK) |-> residual == '0); // R11

    AST_LOGEND_MARK: assert property (@(posedge clk) disable iff (rst)
        (done && res_flags[2]) |-> (res_flags[0] && res_class == CLS_ALERT)); // R5

    AST_BOT_REVERSE: assert property (@(posedge clk) disable iff (rst)
        (done && res_flags[4]) |-> step_dir); // R8

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !step_req)); // R12

endmodule

// File: tb/test_tape_file_skipper.sv
module test_tape_file_skipper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd2;
    logic [15:0] file_count = '0;
    logic        opt_stop_double = 1'b0;
    logic        opt_bot_mark = 1'b0;
    logic        at_bot = 1'b0;
    logic        step_req, step_dir;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_kind = '0;
    logic        busy, done;
    logic [15:0] residual;
    logic [7:0]  res_flags;
    logic [2:0]  res_class;

    tape_file_skipper i_tape_file_skipper (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .mode            (mode),
        .file_count      (file_count),
        .opt_stop_double (opt_stop_double),
        .opt_bot_mark    (opt_bot_mark),
        .at_bot          (at_bot),
        .step_req        (step_req),
        .step_dir        (step_dir),
        .rsp_valid       (rsp_valid),
        .rsp_kind        (rsp_kind),
        .busy            (busy),
        .residual        (residual),
        .done            (done),
        .res_flags       (res_flags),
        .res_class       (res_class)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [7:0]  fl;
        logic [2:0]  cl;
        logic [15:0] rs;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   tape[$];
    int   tpos = 0;
    bit   cur_rev = 1'b0;
    int   checks = 0;
    int   fails = 0;
    int   seen = 0;
    int   issued = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tape side: answer each request one falling edge later
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (step_req) begin
                chk("R3 step direction", {31'd0, step_dir}, {31'd0, cur_rev});
                @(negedge clk);
                chk("R3 single-cycle request", {31'd0, step_req}, 32'd0);
                if (!cur_rev) begin
                    if (tpos == tape.size()) rsp_kind = 3'd3;
                    else begin rsp_kind = 3'(tape[tpos]); tpos++; end
                end else begin
                    if (tpos == 0) rsp_kind = 3'd2;
                    else begin tpos--; rsp_kind = 3'(tape[tpos]); end
                end
                rsp_valid = 1'b1;
            end
        end
    end

    // monitor: compare on the done cycle
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    chk("R12 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " flags"},    {24'd0, res_flags}, {24'd0, e.fl});
                    chk({e.tag, " class"},    {29'd0, res_class}, {29'd0, e.cl});
                    chk({"R2 ", e.tag, " residual"}, {16'd0, residual}, {16'd0, e.rs});
                end
                seen++;
                @(negedge clk);
                chk("R12 done is a pulse", {31'd0, done}, 32'd0);
            end
        end
    end

    task automatic set_tape(input int k[$]);
        tape = k;
    endtask

    task automatic run_skip(input string tag, input int cnt, input bit rev,
                            input bit sd, input bit bm, input int sp);
        exp_t e;
        int   p = sp;
        int   rfc = cnt & 16'hFFFF;
        bit   prev = !rev && (sp == 0) && bm;
        bit   mv = 1'b0;
        bit   fin = 1'b0;
        int   k;
        int   guard = 0;
        e.fl = '0;
        e.cl = '0;
        while (!fin && guard < 200) begin
            guard++;
            if (!rev) begin
                if (p == tape.size()) k = 3;
                else begin k = tape[p]; p++; end
            end else begin
                if (p == 0) k = 2;
                else begin p--; k = tape[p]; end
            end
            case (k)
                0: begin mv = 1'b1; prev = 1'b0; end
                1: begin
                    mv  = 1'b1;
                    rfc = (rfc - 1) & 16'hFFFF;
                    if (prev && sd) begin
                        e.fl = 8'h05 | ((rfc != 0) ? 8'h02 : 8'h00);
                        e.cl = 3'd2;
                        fin  = 1'b1;
                    end else begin
                        prev = 1'b1;
                        if (rfc == 0) begin e.fl = 8'h00; e.cl = 3'd0; fin = 1'b1; end
                    end
                end
                2: begin e.fl = 8'h92; e.cl = 3'd2; fin = 1'b1; end
                3: begin e.fl = 8'h42; e.cl = 3'd6; fin = 1'b1; end
                default: begin mv = 1'b1; e.fl = 8'h22; e.cl = 3'd6; fin = 1'b1; end
            endcase
        end
        if (mv) e.fl = e.fl | 8'h08;
        e.rs  = 16'(rfc);
        e.tag = tag;
        q.push_back(e);
        issued++;

        @(negedge clk);
        tpos            = sp;
        cur_rev         = rev;
        mode            = rev ? 2'd3 : 2'd2;
        file_count      = 16'(cnt);
        opt_stop_double = sd;
        opt_bot_mark    = bm;
        at_bot          = (sp == 0);
        start           = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 residual loaded", {16'd0, residual}, {16'd0, 16'(cnt)});
        while (seen < issued) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset",     {31'd0, done},     32'd0);
        chk("R1 step_req after reset", {31'd0, step_req}, 32'd0);
        chk("R1 busy after reset",     {31'd0, busy},     32'd0);
        chk("R1 residual after reset", {16'd0, residual}, 32'd0);

        set_tape('{0, 0, 1, 0, 1, 0});
        run_skip("R11 R4 forward two files", 2, 1'b0, 1'b0, 1'b0, 0);

        set_tape('{1, 1, 0, 1});
        run_skip("R6 consecutive marks no stop", 3, 1'b0, 1'b0, 1'b0, 0);

        set_tape('{0, 1, 1, 0});
        run_skip("R5 double mark short", 5, 1'b0, 1'b1, 1'b0, 0);

        set_tape('{1, 1});
        run_skip("R5 double mark at zero", 2, 1'b0, 1'b1, 1'b0, 0);

        set_tape('{1, 0, 1, 0, 1});
        run_skip("R6 data between marks with stop", 3, 1'b0, 1'b1, 1'b0, 0);

        set_tape('{1, 0});
        run_skip("R7 leading mark at BOT", 4, 1'b0, 1'b1, 1'b1, 0);

        set_tape('{0, 1, 0, 1});
        run_skip("R7 leading mark away from BOT", 2, 1'b0, 1'b1, 1'b1, 1);

        set_tape('{0, 0, 0});
        run_skip("R8 reverse into BOT", 1, 1'b1, 1'b0, 1'b0, 3);

        set_tape('{0, 0});
        run_skip("R9 end of medium", 1, 1'b0, 1'b0, 1'b0, 0);

        set_tape('{0, 0});
        run_skip("R9 R4 end of medium without motion", 1, 1'b0, 1'b0, 1'b0, 2);

        set_tape('{0, 4, 1});
        run_skip("R10 unreadable record", 1, 1'b0, 1'b0, 1'b0, 0);

        set_tape('{1, 1});
        run_skip("R2 zero count wraps", 0, 1'b0, 1'b1, 1'b0, 0);

        set_tape('{0, 1, 0});
        run_skip("R11 R3 reverse one file", 1, 1'b1, 1'b0, 1'b0, 3);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule